// File: doc/BRIEF.md
# Sequential Instruction Prefetch Queue

This block runs ahead of the instruction decoder and keeps a 16-byte queue filled with the instruction stream. It reads memory one 32-bit doubleword at a time, at doubleword-aligned addresses that climb by four. It has no notion of where instructions begin or end. Fetch requests go to a bus controller that gives execution data cycles priority, so a request is raised only in cycles when the execution side is not using the bus. The decoder takes bytes one per cycle through a valid/ready handshake. Within each doubleword the bytes leave lowest address first.

When a control transfer happens, the core pulses `flush` with the target address. The queue empties at once, and any fetch still in flight is marked stale so that its returning data is thrown away. Fetching then restarts at the doubleword that holds the target. If the target is not doubleword aligned, the leading bytes of that first doubleword are skipped, so the first byte delivered is the byte at the target address.

A four-state controller drives the fetch side:
- `PF_IDLE` waits for room. It moves to `PF_REQ` when at least four bytes are free.
- `PF_REQ` raises the request. It moves to `PF_WAIT` when the bus controller accepts it.
- `PF_WAIT` waits for the read data. It returns to `PF_IDLE` when the data arrives and is written into the queue.
- `PF_DROP` waits for the data of a stale fetch. It returns to `PF_IDLE` when that data arrives, and the data is discarded.

A flush takes priority over every other transition. It goes to `PF_DROP` if an accepted fetch is still unanswered, counting a request accepted in the flush cycle itself. Otherwise it goes to `PF_IDLE`.

Top module: `instr_prefetch_queue`

## Requirements
- R1: While reset is held, `fetch_req` and `byte_valid` are low. After reset the first fetch is at address `RESET_ADDR` (default 0), and the byte stream starts there.
- R2: `fetch_req` is never high in a cycle where `exec_busy` is high.
- R3: A new fetch is started only when at least 4 of the 16 bytes are free. With the decoder stalled, exactly 4 fetches complete after a flush to an aligned target or to a target with byte offset 1, and `fetch_req` then stays low. The queue never holds more than 16 bytes.
- R4: Fetch addresses have bits [1:0] equal to 0. At most one fetch is outstanding. Each completed, non-stale fetch advances the next fetch address by 4.
- R5: Bytes are delivered in memory order, one per cycle in which `byte_valid` and `byte_ready` are both high. Within a doubleword, byte k comes from `rd_data[8k+7:8k]` (little-endian).
- R6: In the cycle after `flush`, `byte_valid` is low.
- R7: Read data from a fetch accepted before or in the flush cycle is discarded. This includes data returning in the flush cycle itself.
- R8: After a flush to address A, the first byte delivered is the byte at A. The `A[1:0]` leading bytes of the first doubleword are skipped.
- R9: While `byte_valid` is high and `byte_ready` is low, with no flush, `byte_valid` stays high and `byte_data` stays stable.
- R10: A raised request keeps `fetch_addr` stable until it is accepted or a flush arrives. It drops only in cycles where `exec_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Control transfer: clear the queue and redirect |
| flush_addr | input | 32 | Byte address to restart fetching from |
| exec_busy | input | 1 | The bus is taken by an execution data cycle this cycle |
| fetch_req | output | 1 | Doubleword fetch request |
| fetch_addr | output | 32 | Aligned address of the requested doubleword |
| fetch_ack | input | 1 | The bus controller accepts the request this cycle |
| rd_valid | input | 1 | Read data of the outstanding fetch is present |
| rd_data | input | 32 | Read doubleword, with the lowest address in bits [7:0] |
| byte_valid | output | 1 | A queued byte is offered to the decoder |
| byte_data | output | 8 | Oldest queued byte |
| byte_ready | input | 1 | The decoder takes the offered byte |

## Verification
Two functions can fall in the same cycle:
- a redirect, which clears the queue and moves the address;
- the return of read data for the old stream.

The bench provokes this in two ways. It holds a requested flush until the cycle in which its bus model answers an outstanding fetch. It also flushes at arbitrary points of the fetch cycle, including the cycle in which a request is accepted. The outcome is judged by a byte scoreboard that is reloaded with the new stream at the flush: any surviving old byte or misplaced skip shows up as a mismatch. The bench also checks that the fetch address sequence restarts at the aligned target.

// File: rtl/pq_pkg.sv
package pq_pkg;
    localparam int PF_WORD_BYTES = 4;
    localparam int PF_OFF_W      = $clog2(PF_WORD_BYTES);
    localparam int PF_DATA_W     = PF_WORD_BYTES * 8;

    typedef enum logic [1:0] {
        PF_IDLE,
        PF_REQ,
        PF_WAIT,
        PF_DROP
    } pf_state_e;
endpackage

// File: rtl/pq_byte_ring.sv
module pq_byte_ring
    import pq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [PF_OFF_W:0]     wr_num,
    input  logic [PF_DATA_W-1:0]  wr_data,
    input  logic                  rd_en,
    output logic                  not_empty,
    output logic                  space_ok,
    output logic [7:0]            head_byte
);
    // DEPTH must be a power of two so the pointers wrap by overflow.
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] add_n, sub_n;

    assign add_n     = wr_en ? CNT_W'(wr_num) : '0;
    assign sub_n     = rd_en ? CNT_W'(1) : '0;
    assign not_empty = (count != '0);
    assign space_ok  = (count <= CNT_W'(DEPTH - PF_WORD_BYTES));
    assign head_byte = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(add_n);
            rd_ptr <= rd_ptr + PTR_W'(sub_n);
            count  <= count + add_n - sub_n;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            for (int k = 0; k < PF_WORD_BYTES; k++) begin
                if (k < int'(wr_num)) begin
                    mem[wr_ptr + PTR_W'(k)] <= wr_data[8*k +: 8];
                end
            end
        end
    end

    // R3: the controller only writes when the whole write fits
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, count} + {1'b0, add_n}) <= (CNT_W + 1)'(DEPTH));
endmodule

// File: rtl/pq_fetch_fsm.sv
module pq_fetch_fsm
    import pq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [ADDR_W-1:0]   flush_addr,
    input  logic                exec_busy,
    input  logic                space_ok,
    input  logic                fetch_ack,
    input  logic                rd_valid,
    output logic                fetch_req,
    output logic [ADDR_W-1:0]   fetch_addr,
    output logic                wr_en,
    output logic [PF_OFF_W:0]   wr_num,
    output logic [PF_OFF_W-1:0] skip
);
    pf_state_e st, nxt;
    logic      accepted;

    assign accepted = fetch_req && fetch_ack;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= PF_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (flush) begin
            if ((st == PF_WAIT && !rd_valid) || (st == PF_DROP && !rd_valid) ||
                (st == PF_REQ && accepted))
                nxt = PF_DROP;
            else
                nxt = PF_IDLE;
        end else begin
            unique case (st)
                PF_IDLE: if (space_ok) nxt = PF_REQ;
                PF_REQ:  if (accepted) nxt = PF_WAIT;
                PF_WAIT: if (rd_valid) nxt = PF_IDLE;
                PF_DROP: if (rd_valid) nxt = PF_IDLE;
                default: nxt = PF_IDLE;
            endcase
        end
    end

    always_comb begin
        fetch_req = (st == PF_REQ) && !exec_busy;
        wr_en     = (st == PF_WAIT) && rd_valid && !flush;
        wr_num    = (PF_OFF_W + 1)'(PF_WORD_BYTES) - {1'b0, skip};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_addr <= {RESET_ADDR[ADDR_W-1:PF_OFF_W], PF_OFF_W'(0)};
            skip       <= '0;
        end else if (flush) begin
            fetch_addr <= {flush_addr[ADDR_W-1:PF_OFF_W], PF_OFF_W'(0)};
            skip       <= flush_addr[PF_OFF_W-1:0];
        end else if (wr_en) begin
            fetch_addr <= fetch_addr + ADDR_W'(PF_WORD_BYTES);
            skip       <= '0;
        end
    end

    // R4: every request targets a whole doubleword
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> fetch_addr[PF_OFF_W-1:0] == '0);
    // R10: an unaccepted request keeps its address
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack && !flush) |=> (st == PF_REQ) && $stable(fetch_addr));
endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue
    import pq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DEPTH      = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [ADDR_W-1:0]    flush_addr,
    input  logic                 exec_busy,
    output logic                 fetch_req,
    output logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 fetch_ack,
    input  logic                 rd_valid,
    input  logic [PF_DATA_W-1:0] rd_data,
    output logic                 byte_valid,
    output logic [7:0]           byte_data,
    input  logic                 byte_ready
);
    logic                  space_ok, wr_en, not_empty;
    logic [PF_OFF_W:0]     wr_num;
    logic [PF_OFF_W-1:0]   skip;
    logic [PF_DATA_W-1:0]  aligned_data;

    pq_fetch_fsm #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .exec_busy(exec_busy), .space_ok(space_ok), .fetch_ack(fetch_ack),
        .rd_valid(rd_valid), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .wr_en(wr_en), .wr_num(wr_num), .skip(skip)
    );

    // drop the skipped leading bytes so lane 0 holds the first kept byte
    assign aligned_data = rd_data >> {skip, 3'b000};

    pq_byte_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .clear(flush), .wr_en(wr_en),
        .wr_num(wr_num), .wr_data(aligned_data),
        .rd_en(byte_valid && byte_ready), .not_empty(not_empty),
        .space_ok(space_ok), .head_byte(byte_data)
    );

    assign byte_valid = not_empty;

    // R6: a redirect leaves nothing to offer in the next cycle
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !byte_valid);
    // R9: an offered byte waits unchanged for the decoder
    p_hold_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready && !flush) |=> byte_valid && $stable(byte_data));
endmodule

// File: tb/instr_prefetch_queue_bench.sv
`timescale 1ns/1ps
module instr_prefetch_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] flush_addr = '0;
    logic        exec_busy = 1'b0;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_ready = 1'b0;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [7:0]  exp_q [$];
    bit          hold_bus = 0, busy_pat = 0, flush_req = 0, flush_on_ret = 0;
    logic [31:0] req_addr = '0;
    int          ack_cnt = 0;

    always #2.5 clk = ~clk;

    instr_prefetch_queue u_instr_prefetch_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .exec_busy(exec_busy), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready)
    );

    function automatic logic [7:0] mb(input logic [31:0] a);
        return a[7:0] * 8'd37 + a[15:8] + 8'h5C;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // bus model, flush driver and expected-stream driver
    initial begin
        int cyc = 0, cnt = 0;
        bit pend = 0, stale = 0, fl_prev = 0, first_ack = 1, req_prev = 0;
        logic [31:0] paddr = '0, exp_fa = '0, addr_prev = '0;
        forever begin
            bit ret, ret_live, did_fl;
            @(negedge clk);
            flush = 0; rd_valid = 0; fetch_ack = 0;
            if (!rst_n) continue;
            cyc++;
            exec_busy = hold_bus || (busy_pat && (cyc % 3 != 0));
            ret = 0; ret_live = 0; did_fl = 0;
            if (pend) begin
                if (cnt <= 1) begin
                    ret = 1; pend = 0; rd_valid = 1;
                    rd_data = {mb(paddr + 3), mb(paddr + 2), mb(paddr + 1), mb(paddr)};
                    ret_live = !stale; stale = 0;
                end else cnt--;
            end
            if (flush_req && (!flush_on_ret || ret)) begin
                flush = 1; flush_addr = req_addr;
                exp_q.delete();
                for (int i = 0; i < 600; i++) exp_q.push_back(mb(req_addr + i));
                ack_cnt = 0; flush_req = 0; did_fl = 1;
                if (pend) stale = 1;
                exp_fa = {req_addr[31:2], 2'b00};
            end
            if (ret_live && !did_fl) exp_fa += 4;
            #1;
            if (exec_busy) chk(!fetch_req, "R2 request under busy", 32'(fetch_req), 0);
            if (fl_prev) chk(!byte_valid, "R6 valid after flush", 32'(byte_valid), 0);
            if (req_prev && !exec_busy && !did_fl)
                chk(fetch_req && fetch_addr == addr_prev, "R10 request held", fetch_addr, addr_prev);
            fl_prev = did_fl;
            req_prev = 0;
            if (!pend && fetch_req) begin
                if ((cyc % 4) != 2) begin
                    fetch_ack = 1; pend = 1; paddr = fetch_addr; cnt = 1 + (cyc % 3); ack_cnt++;
                    if (first_ack) chk(fetch_addr == 0, "R1 first fetch address", fetch_addr, 0);
                    first_ack = 0;
                    if (did_fl) stale = 1;
                    else chk(fetch_addr == exp_fa, "R4 fetch address", fetch_addr, exp_fa);
                end else begin
                    req_prev = 1; addr_prev = fetch_addr;
                end
            end
        end
    end

    // monitor: pops the expected stream on every handshake
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && !flush && byte_valid && byte_ready) begin
                if (exp_q.size() == 0) chk(0, "R5 unexpected byte", 32'(byte_data), 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(byte_data == e, "R5/R8 byte order", 32'(byte_data), 32'(e));
                end
            end
        end
    end

    task automatic run(input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_ready = (pat == 0) ? 1'b1 : ((i % pat) != 1);
        end
    endtask

    task automatic do_flush(input logic [31:0] a, input bit on_ret);
        req_addr = a; flush_on_ret = on_ret; flush_req = 1;
        while (flush_req) @(negedge clk);
    endtask

    task automatic fill_test(input logic [31:0] a);
        hold_bus = 1;
        byte_ready = 0;
        repeat (6) @(negedge clk);
        do_flush(a, 0);
        hold_bus = 0;
        repeat (60) @(negedge clk);
        chk(ack_cnt == 4, "R3 fetch count when stalled", 32'(ack_cnt), 4);
        chk(!fetch_req, "R3 no request when full", 32'(fetch_req), 0);
        chk(byte_valid && byte_data == mb(a), "R8 first byte at target", 32'(byte_data), 32'(mb(a)));
        repeat (5) @(negedge clk);
        chk(byte_valid && byte_data == mb(a), "R9 held byte stable", 32'(byte_data), 32'(mb(a)));
        run(80, 0);
    endtask

    initial begin
        for (int i = 0; i < 600; i++) exp_q.push_back(mb(i));
        repeat (3) @(negedge clk);
        chk(!fetch_req && !byte_valid, "R1 reset outputs", {fetch_req, byte_valid}, 0);
        rst_n = 1;
        run(100, 0);
        busy_pat = 1;
        run(200, 3);
        do_flush(32'h0000_1000, 0);
        run(150, 4);
        do_flush(32'h0000_2003, 0);
        run(150, 0);
        do_flush(32'h0000_3001, 1);          // R7: flush in the data-return cycle
        run(150, 5);
        busy_pat = 0;
        do_flush(32'h0000_3802, 1);          // R7 again without bus contention
        run(100, 0);
        fill_test(32'h0000_4000);
        fill_test(32'h0000_5001);
        busy_pat = 1;
        for (int j = 0; j < 6; j++) begin    // R7: flushes at assorted fetch phases
            do_flush(32'h0000_6000 + 32'(j * 67), 0);
            run(13 + j, 2);
        end
        run(150, 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end
endmodule